// File: doc/BRIEF.md
# DAC Sample FIFO with Number-Format Conversion

This block buffers samples between a host and a digital-to-analog converter. The host writes 16-bit words to a single write-only data address. Each accepted word goes into a first-in first-out store whose depth is fixed at elaboration: 2048 entries, 512 entries, or zero entries. In the zero-entry form the store is a single holding slot. The store reports its fill state on status outputs, so the host knows it may keep writing for as long as the full flag is low.

On the converter side, each update strobe removes the oldest sample and turns it into the unsigned code the converter expects. Two mode inputs govern the conversion. The format input selects straight binary or two's complement. The resolution input selects a 16-bit or a 12-bit converter. The code is registered and held until the next successful update. A write that finds the store full is dropped and flagged with an overflow pulse. An update that finds the store empty keeps the previous code and is flagged with an underrun pulse.

Top module: `dac_sample_fifo`

## Requirements
- R1: A word is accepted only in a cycle where `host_wr_en` is high and `host_addr` equals 0x1E. A write strobe at any other address, and an address of 0x1E without the strobe, leave the store unchanged.
- R2: With a nonzero `DEPTH`, up to `DEPTH` words are held. They leave in the order they were written, one per accepted `dac_update`.
- R3: With a nonzero depth, the status flags follow the occupancy as it stands after each clock edge. `stat_empty` is high at occupancy 0. `stat_full` is high at occupancy `DEPTH`. `stat_half` is high at an occupancy of `DEPTH/2` or more.
- R4: A write while `stat_full` is high is dropped and leaves the stored contents unchanged. `err_overflow` is high for exactly the one cycle after that clock edge.
- R5: A `dac_update` while the store is empty leaves `dac_code` unchanged. `err_underrun` is high for exactly the one cycle after that edge.
- R6: A write and an update in the same cycle, with the store neither empty nor full, leave the occupancy unchanged. The oldest word leaves and the new word enters.
- R7: With `bipolar_mode` = 0 and `res_16` = 1, `dac_code` after an update equals the word as written.
- R8: With `bipolar_mode` = 1 and `res_16` = 1, `dac_code` equals the word with bit 15 inverted. For example, 0x8000 (-32768) gives 0x0000 and 0x7FFF gives 0xFFFF.
- R9: With `res_16` = 0, only bits 11:0 of the word carry the sample and bits 15:12 of `dac_code` are 0. Bipolar mode inverts bit 11: for example, 0x0800 (-2048) gives 0x0000 and 0x07FF gives 0x0FFF. The mode inputs are sampled at the update edge.
- R10: With `DEPTH` = 0, one word is held. `stat_full` is high while it is held, and `stat_empty` and `stat_half` stay low.
- R11: Reset empties the store and clears `dac_code`, `err_overflow`, `err_underrun`, `stat_full` and `stat_half`. `stat_empty` is high after reset when `DEPTH` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | ADDR_W | Host register address |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| bipolar_mode | input | 1 | 1: two's complement samples, 0: straight binary |
| res_16 | input | 1 | 1: 16-bit converter, 0: 12-bit converter |
| dac_update | input | 1 | Converter update strobe; removes one sample |
| dac_code | output | 16 | Registered converter code |
| stat_empty | output | 1 | Store empty (low when DEPTH = 0) |
| stat_half | output | 1 | Occupancy at least DEPTH/2 (low when DEPTH = 0) |
| stat_full | output | 1 | Store full, or holding slot occupied |
| err_overflow | output | 1 | One-cycle pulse: a write was dropped |
| err_underrun | output | 1 | One-cycle pulse: an update found no sample |

## Verification
The assertions assume that the host write strobe, the update strobe and the mode inputs are clean synchronous levels that change only between clock edges. The steadiness check on simultaneous write and update also assumes the write targets the data address. The stimulus drives every input on the falling edge and changes the format and resolution inputs only while no update is pending. It issues simultaneous writes and updates only when the store holds at least one word, so the bench's queue occupancy always matches the occupancy the design saw at that edge.

// File: rtl/dac_fifo_pkg.sv
package dac_fifo_pkg;
   localparam int unsigned SAMPLE_W = 16;

   typedef enum logic {
      FMT_STRAIGHT = 1'b0,
      FMT_TWOS     = 1'b1
   } num_fmt_e;

   typedef enum logic {
      RES_NARROW = 1'b0,
      RES_WIDE   = 1'b1
   } dac_res_e;
endpackage

// File: rtl/dac_code_conv.sv
module dac_code_conv
   import dac_fifo_pkg::*;
#(
   parameter int unsigned W        = SAMPLE_W,
   parameter int unsigned NARROW_W = 12
) (
   input  logic [W-1:0] sample,
   input  num_fmt_e     fmt,
   input  dac_res_e     res,
   output logic [W-1:0] code
);
   localparam logic [W-1:0] WIDE_SIGN   = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] NARROW_SIGN = {{(W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
   localparam logic [W-1:0] NARROW_MASK = {{(W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [W-1:0] base;
   logic [W-1:0] flip;

   always_comb begin
      if (res == RES_WIDE) begin
         base = sample;
         flip = WIDE_SIGN;
      end else begin
         base = sample & NARROW_MASK;
         flip = NARROW_SIGN;
      end
      code = (fmt == FMT_TWOS) ? (base ^ flip) : base;
   end
endmodule

// File: rtl/dac_fifo_store.sv
module dac_fifo_store #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         half
);
   generate
      if (DEPTH == 0) begin : g_slot
         logic         held;
         logic [W-1:0] slot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held   <= 1'b0;
               slot_q <= '0;
            end else if (push && !held) begin
               held   <= 1'b1;
               slot_q <= wdata;
            end else if (pop && held) begin
               held   <= 1'b0;
            end
         end

         assign head  = slot_q;
         assign empty = !held;
         assign full  = held;
         assign half  = 1'b0;
      end else begin : g_ring
         localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
         localparam int unsigned CW = $clog2(DEPTH + 1);
         localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
         localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wr_ptr;
         logic [AW-1:0] rd_ptr;
         logic [CW-1:0] occ;
         logic          do_push;
         logic          do_pop;

         assign do_push = push && (occ != FULL_CNT);
         assign do_pop  = pop && (occ != '0);

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= wdata;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               occ    <= '0;
            end else begin
               if (do_push) wr_ptr <= wr_ptr + 1'b1;
               if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   occ <= occ + 1'b1;
                  2'b01:   occ <= occ - 1'b1;
                  default: occ <= occ;
               endcase
            end
         end

         assign head  = mem[rd_ptr];
         assign empty = (occ == '0);
         assign full  = (occ == FULL_CNT);
         assign half  = (occ >= HALF_CNT);
      end
   endgenerate
endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
   import dac_fifo_pkg::*;
#(
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned NARROW_W  = 12,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h1E
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic                host_wr_en,
   input  logic [15:0]         host_wdata,
   input  logic                bipolar_mode,
   input  logic                res_16,
   input  logic                dac_update,
   output logic [15:0]         dac_code,
   output logic                stat_empty,
   output logic                stat_half,
   output logic                stat_full,
   output logic                err_overflow,
   output logic                err_underrun
);
   generate
      if (!(DEPTH == 0 || DEPTH == 512 || DEPTH == 2048)) begin : g_bad_depth
         $error("dac_sample_fifo: DEPTH must be 0, 512 or 2048");
      end
      if (NARROW_W == 0 || NARROW_W >= SAMPLE_W) begin : g_bad_narrow
         $error("dac_sample_fifo: NARROW_W must lie between 1 and SAMPLE_W-1");
      end
   endgenerate

   logic                wr_hit;
   logic                fifo_empty;
   logic                fifo_full;
   logic                fifo_half;
   logic [SAMPLE_W-1:0] head_word;
   logic [SAMPLE_W-1:0] next_code;

   assign wr_hit = host_wr_en && (host_addr == DATA_ADDR);

   dac_fifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_hit),
      .wdata (host_wdata),
      .pop   (dac_update),
      .head  (head_word),
      .empty (fifo_empty),
      .full  (fifo_full),
      .half  (fifo_half)
   );

   dac_code_conv #(.W(SAMPLE_W), .NARROW_W(NARROW_W)) u_conv (
      .sample (head_word),
      .fmt    (num_fmt_e'(bipolar_mode)),
      .res    (dac_res_e'(res_16)),
      .code   (next_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_code     <= '0;
         err_overflow <= 1'b0;
         err_underrun <= 1'b0;
      end else begin
         if (dac_update && !fifo_empty) dac_code <= next_code;
         err_overflow <= wr_hit && fifo_full;
         err_underrun <= dac_update && fifo_empty;
      end
   end

   generate
      if (DEPTH == 0) begin : g_flags_slot
         assign stat_empty = 1'b0;
         assign stat_half  = 1'b0;
      end else begin : g_flags_ring
         assign stat_empty = fifo_empty;
         assign stat_half  = fifo_half;
      end
   endgenerate
   assign stat_full = fifo_full;
endmodule

module dac_sample_fifo_chk #(
   parameter int unsigned DEPTH = 512
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_hit,
   input logic        dac_update,
   input logic        fifo_empty,
   input logic [15:0] dac_code,
   input logic        stat_empty,
   input logic        stat_half,
   input logic        stat_full,
   input logic        err_overflow,
   input logic        err_underrun
);
   // R4: an overflow pulse needs a write at a full store one edge earlier
   a_r4_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> $past(wr_hit && stat_full));

   // R4: a write alone cannot take a full store out of full
   a_r4_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_full && wr_hit && !dac_update) |=> stat_full);

   // R5: an underrun pulse needs an update at an empty store
   a_r5_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_underrun |-> $past(dac_update && fifo_empty));

   // R5: the code is held across an underrun
   a_r5_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      err_underrun |-> $stable(dac_code));

   // R7: the code moves only after an update strobe
   a_r7_code_on_update: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dac_update) |-> $stable(dac_code));

   // R6: a simultaneous write and update keep every flag
   a_r6_steady_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && dac_update && !fifo_empty && !stat_full)
      |=> ($stable(stat_empty) && $stable(stat_full) && $stable(stat_half)));

   generate
      if (DEPTH == 0) begin : g_chk_slot
         // R10: the slot form reports only full
         a_r10_slot_flags: assert property (@(posedge clk) disable iff (!rst_n)
            !stat_empty && !stat_half);
      end else begin : g_chk_ring
         // R3: empty and full are exclusive
         a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(stat_empty && stat_full));
         // R3: full implies half
         a_r3_full_has_half: assert property (@(posedge clk) disable iff (!rst_n)
            stat_full |-> stat_half);
      end
   endgenerate
endmodule

bind dac_sample_fifo dac_sample_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_hit       (wr_hit),
   .dac_update   (dac_update),
   .fifo_empty   (fifo_empty),
   .dac_code     (dac_code),
   .stat_empty   (stat_empty),
   .stat_half    (stat_half),
   .stat_full    (stat_full),
   .err_overflow (err_overflow),
   .err_underrun (err_underrun)
);

// File: tb/dac_sample_fifo_bench.sv
module dac_sample_fifo_bench;
   localparam int DEPTH = 512;
   localparam logic [7:0] DADDR = 8'h1E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  host_addr = '0;
   logic        host_wr_en = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        bipolar_mode = 1'b0;
   logic        res_16 = 1'b1;
   logic        dac_update = 1'b0;
   logic [15:0] dac_code;
   logic        stat_empty, stat_half, stat_full, err_overflow, err_underrun;

   logic        z_wr = 1'b0;
   logic [15:0] z_data = '0;
   logic        z_upd = 1'b0;
   logic [15:0] z_code;
   logic        z_empty, z_half, z_full, z_ovf, z_und;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   logic [15:0] q[$];
   logic [15:0] last_code = '0;

   always #10 clk = ~clk;

   dac_sample_fifo #(.DEPTH(DEPTH)) u_dac_sample_fifo (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
      .host_wdata(host_wdata), .bipolar_mode(bipolar_mode), .res_16(res_16),
      .dac_update(dac_update), .dac_code(dac_code), .stat_empty(stat_empty),
      .stat_half(stat_half), .stat_full(stat_full), .err_overflow(err_overflow),
      .err_underrun(err_underrun));

   dac_sample_fifo #(.DEPTH(0)) u_dac_sample_fifo_z (
      .clk(clk), .rst_n(rst_n), .host_addr(DADDR), .host_wr_en(z_wr),
      .host_wdata(z_data), .bipolar_mode(bipolar_mode), .res_16(res_16),
      .dac_update(z_upd), .dac_code(z_code), .stat_empty(z_empty),
      .stat_half(z_half), .stat_full(z_full), .err_overflow(z_ovf),
      .err_underrun(z_und));

   function automatic logic [15:0] to_code(input logic [15:0] w, input logic bip, input logic wide);
      logic [15:0] c;
      if (wide) c = bip ? {~w[15], w[14:0]} : w;
      else      c = bip ? {4'h0, ~w[11], w[10:0]} : {4'h0, w[11:0]};
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [7:0] a, input logic [15:0] d, input logic up);
      @(negedge clk);
      host_wr_en = wr; host_addr = a; host_wdata = d; dac_update = up;
      if (wr && a == DADDR && q.size() < DEPTH) q.push_back(d);
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 16'h0000, 1'b0);
   endtask

   task automatic zstep(input logic wr, input logic [15:0] d, input logic up);
      @(negedge clk);
      z_wr = wr; z_data = d; z_upd = up;
   endtask

   // scoreboard monitor
   always begin
      @(posedge clk);
      if (rst_n && dac_update) begin
         if (q.size() > 0) begin
            logic [15:0] exp;
            string tag;
            tag = res_16 ? (bipolar_mode ? "R8 R2" : "R7 R2") : "R9 R2";
            exp = to_code(q.pop_front(), bipolar_mode, res_16);
            last_code = exp;
            @(negedge clk);
            chk(dac_code == exp && !err_underrun, tag, {15'd0, err_underrun, dac_code}, {16'd0, exp});
         end else begin
            @(negedge clk);
            chk(err_underrun && dac_code == last_code, "R5 underrun",
                {15'd0, err_underrun, dac_code}, {16'd1, last_code});
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk(stat_empty && !stat_full && !stat_half, "R11 flags", {stat_empty, stat_full, stat_half}, 3'b100);
      chk(dac_code == 16'h0 && !err_overflow && !err_underrun, "R11 code", {err_overflow, err_underrun, dac_code}, 0);
      chk(!z_full && !z_empty && !z_half, "R11 R10 slot flags", {z_empty, z_full, z_half}, 0);

      // R1 address decode
      step(1'b1, 8'h1C, 16'h1234, 1'b0); idle();
      chk(stat_empty, "R1 other address", stat_empty, 1);
      step(1'b0, DADDR, 16'h1234, 1'b0); idle();
      chk(stat_empty, "R1 no strobe", stat_empty, 1);

      // R7 unipolar 16-bit
      bipolar_mode = 1'b0; res_16 = 1'b1;
      step(1'b1, DADDR, 16'h0000, 1'b0);
      step(1'b1, DADDR, 16'hFFFF, 1'b0);
      step(1'b1, DADDR, 16'h1234, 1'b0); idle();
      chk(!stat_empty && !stat_half, "R3 partial", {stat_empty, stat_half}, 0);
      repeat (3) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();
      chk(stat_empty, "R3 drained", stat_empty, 1);

      // R8 bipolar 16-bit
      bipolar_mode = 1'b1;
      step(1'b1, DADDR, 16'h0000, 1'b0);
      step(1'b1, DADDR, 16'h7FFF, 1'b0);
      step(1'b1, DADDR, 16'h8000, 1'b0);
      step(1'b1, DADDR, 16'hFFFF, 1'b0);
      repeat (4) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();

      // R9 12-bit
      bipolar_mode = 1'b0; res_16 = 1'b0;
      step(1'b1, DADDR, 16'hF123, 1'b0);
      step(1'b1, DADDR, 16'h0FFF, 1'b0);
      repeat (2) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();
      bipolar_mode = 1'b1;
      step(1'b1, DADDR, 16'h0800, 1'b0);
      step(1'b1, DADDR, 16'h07FF, 1'b0);
      step(1'b1, DADDR, 16'hAFFF, 1'b0);
      repeat (3) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();

      // R5 underrun on empty store
      step(1'b0, 8'h00, 16'h0, 1'b1); idle(); idle();
      chk(!err_underrun && !err_overflow, "R5 pulse width", {err_underrun, err_overflow}, 0);

      // R3 half and full, R4 overflow
      bipolar_mode = 1'b0; res_16 = 1'b1;
      for (int i = 0; i < DEPTH/2 - 1; i++) step(1'b1, DADDR, 16'(i + 16'h0100), 1'b0);
      idle();
      chk(!stat_half && !stat_empty, "R3 below half", {stat_empty, stat_half}, 0);
      step(1'b1, DADDR, 16'hA5A5, 1'b0); idle();
      chk(stat_half && !stat_full, "R3 at half", {stat_half, stat_full}, 2'b10);
      for (int i = DEPTH/2; i < DEPTH; i++) step(1'b1, DADDR, 16'(i * 3), 1'b0);
      idle();
      chk(stat_full && stat_half, "R3 full", {stat_full, stat_half}, 2'b11);
      step(1'b1, DADDR, 16'hDEAD, 1'b0); idle();
      chk(err_overflow && stat_full, "R4 overflow pulse", {err_overflow, stat_full}, 2'b11);
      idle();
      chk(!err_overflow && stat_full, "R4 pulse ends", {err_overflow, stat_full}, 2'b01);
      for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();
      chk(stat_empty && !stat_half, "R4 R3 drained after overflow", {stat_empty, stat_half}, 2'b10);

      // R6 simultaneous write and update
      step(1'b1, DADDR, 16'h1111, 1'b0);
      step(1'b1, DADDR, 16'h2222, 1'b0);
      step(1'b1, DADDR, 16'h3333, 1'b1); idle();
      chk(!stat_empty && !stat_full, "R6 occupancy kept", {stat_empty, stat_full}, 0);
      repeat (2) step(1'b0, 8'h00, 16'h0, 1'b1);
      idle(); idle();
      chk(stat_empty, "R6 two words left", stat_empty, 1);
      step(1'b0, 8'h00, 16'h0, 1'b1); idle(); idle();

      // R10 zero-depth slot
      bipolar_mode = 1'b1; res_16 = 1'b1;
      zstep(1'b1, 16'h8001, 1'b0); zstep(1'b0, 16'h0, 1'b0);
      chk(z_full && !z_empty && !z_half, "R10 slot held", {z_full, z_empty, z_half}, 3'b100);
      zstep(1'b1, 16'h5555, 1'b0); zstep(1'b0, 16'h0, 1'b0);
      chk(z_ovf && z_full, "R10 R4 slot overflow", {z_ovf, z_full}, 2'b11);
      zstep(1'b0, 16'h0, 1'b1); zstep(1'b0, 16'h0, 1'b0);
      chk(z_code == 16'h0001 && !z_full, "R10 R8 slot output", {15'd0, z_full, z_code}, 32'h0001);
      zstep(1'b0, 16'h0, 1'b1); zstep(1'b0, 16'h0, 1'b0);
      chk(z_und && z_code == 16'h0001, "R10 R5 slot underrun", {15'd0, z_und, z_code}, 32'h10001);

      idle(); idle();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule